// File: doc/BRIEF.md
# Interleaved Two-Stage Gate Pulse Generator

This block drives two power stages from one programmable switching period. A boost power-factor stage gets its pulse at the start of every period. A forward converter stage gets its pulse a fixed off-time after the boost pulse has ended, so the two switches never conduct together and their switching edges are spread apart. Duty requests arrive as digital on-time counts. Each stage clamps its request to its own cap: about 97% of the period for the boost stage, and a choice of 50% or about 65% for the forward stage. A level input picks the forward cap.

Each stage has a digital current-limit input. That input ends the running pulse of its own stage for the rest of the period, but it is ignored during a blanking window that opens at each turn-on. Each stage also has an enable that drops its gate within one clock. When a light-load flag is held, the period grows by a fixed step at every boundary, up to a ceiling, which lowers the switching frequency. All times are counted in system clock cycles. With the default 100 MHz clock, a period count of 1538 gives about 65 kHz.

Top module: `ilv_gate_pulser`

## Requirements
- R1: The active period P is `periodCfg` clamped to the range MIN_PERIOD to MAX_PERIOD. With `lightLoad` low, successive rising edges of `boostGate` are exactly P clocks apart, and each rises one clock after the first clock of its period.
- R2: The boost pulse width is min(`boostDuty`, P - floor(P/32)) clocks. The request is sampled at the period start. A zero request, or `boostEn` low at the period start, gives no boost pulse in that period.
- R3: `fwdGate` rises only after `boostGate` has been low for exactly OFF_TIME consecutive clocks after the boost pulse fell (or after the first clock of the period when there was no boost pulse). The two gates are never high together.
- R4: The forward pulse width is min(`fwdDuty`, cap). The cap is floor(P/2) when `dutySel` is 0, and floor(P/2)+floor(P/8)+floor(P/32) when `dutySel` is 1. The pulse is cut at the period end, and no forward pulse occurs when its start would fall on or after that end.
- R5: A high current-limit input seen after more than BLANK_CYC clocks of a pulse drives that stage's gate low on the next clock. The gate stays low for the rest of the period.
- R6: A current-limit input has no effect during the first BLANK_CYC clocks of each pulse of its stage.
- R7: An enable going low drives its gate low on the next clock. The pulse does not restart before the next period, even if the enable returns high.
- R8: `lightLoad` is sampled at each period boundary. When it is high, the next period is min(P_current + STRETCH_STEP, MAX_PERIOD). When it is low, the next period is the clamped `periodCfg`.
- R9: Both gates are low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periodCfg | input | CNT_W | Nominal switching period in clocks |
| lightLoad | input | 1 | Light-load flag; stretches the period while high |
| dutySel | input | 1 | Forward cap select: 0 = 50%, 1 = about 65% |
| boostEn | input | 1 | Boost stage enable |
| boostDuty | input | CNT_W | Boost on-time request in clocks |
| boostIlim | input | 1 | Boost current-limit comparator result |
| fwdEn | input | 1 | Forward stage enable |
| fwdDuty | input | CNT_W | Forward on-time request in clocks |
| fwdIlim | input | 1 | Forward current-limit comparator result |
| boostGate | output | 1 | Boost stage gate pulse |
| fwdGate | output | 1 | Forward stage gate pulse |

## Verification
Each result has a fixed delay from its stimulus:
- Inputs sampled at a period boundary take effect in the period that begins one clock later.
- The boost gate rises one clock after that period's first clock.
- A dropped enable or an unblanked current limit shows as a low gate one clock after it is applied.
- The forward gate rises OFF_TIME clocks after the boost gate was first seen low.

The bench samples both gates half a clock after each active edge and records the tick of every rising and falling edge. It changes its inputs only just after a boost rising edge, then lets a full period pass before it measures, and it computes every width, gap and period length from those tick stamps.

// File: rtl/ilv_gate_pkg.sv
package ilv_gate_pkg;

  // Channel indices of the two gate stages.
  localparam int CH_BOOST = 0;
  localparam int CH_FWD   = 1;
  localparam int NUM_CH   = 2;

  // Strobes from the period controller to the pulse datapath.
  typedef struct packed {
    logic periodStart;  // first clock of a switching period
    logic periodEnd;    // last clock of a switching period
  } ilv_strobe_t;

endpackage

// File: rtl/ilv_period_ctrl.sv
module ilv_period_ctrl
  import ilv_gate_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int MIN_PERIOD   = 64,
  parameter int MAX_PERIOD   = 3076,
  parameter int STRETCH_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             lightLoad,
  input  logic             dutySel,
  output ilv_strobe_t      strb,
  output logic [CNT_W-1:0] boostCap,
  output logic [CNT_W-1:0] fwdCap
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MAX_P = CNT_W'(MAX_PERIOD);
  localparam logic [SUM_W-1:0] STEP_S = SUM_W'(STRETCH_STEP);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] curPer;
  logic [CNT_W-1:0] nomPer;
  logic [CNT_W-1:0] nextPer;
  logic [SUM_W-1:0] stretched;
  logic             startPend;
  logic             wrapNow;
  logic             startQ;

  // Nominal period, held inside the legal range.
  always_comb begin
    if (periodCfg < MIN_P)      nomPer = MIN_P;
    else if (periodCfg > MAX_P) nomPer = MAX_P;
    else                        nomPer = periodCfg;
  end

  // Length of the next period: stretched under light load, else nominal.
  always_comb begin
    stretched = {1'b0, curPer} + STEP_S;
    if (startPend || !lightLoad)        nextPer = nomPer;
    else if (stretched > {1'b0, MAX_P}) nextPer = MAX_P;
    else                                nextPer = stretched[CNT_W-1:0];
  end

  assign wrapNow = startPend || (phaseCnt == (curPer - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt  <= '0;
      curPer    <= MIN_P;
      startPend <= 1'b1;
      startQ    <= 1'b0;
    end else begin
      startPend <= 1'b0;
      startQ    <= wrapNow;
      if (wrapNow) begin
        phaseCnt <= '0;
        curPer   <= nextPer;
      end else begin
        phaseCnt <= phaseCnt + CNT_W'(1);
      end
    end
  end

  // Caps made from shifts: 1 - 1/32 for boost, 1/2 or 1/2+1/8+1/32 for forward.
  always_comb begin
    boostCap = curPer - (curPer >> 5);
    if (dutySel) fwdCap = (curPer >> 1) + (curPer >> 3) + (curPer >> 5);
    else         fwdCap = curPer >> 1;
  end

  assign strb.periodStart = startQ;
  assign strb.periodEnd   = wrapNow;

  // R1: the phase counter stays inside the active period
  a_r1_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !startPend |-> (phaseCnt < curPer));

  // R8: the period never leaves its legal range
  a_r8_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !startPend |-> (curPer >= MIN_P && curPer <= MAX_P));

  // R8: a boundary under light load never shortens the period
  a_r8_stretch_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (startQ && $past(lightLoad) && !$past(startPend)) |-> (curPer >= $past(curPer)));

endmodule

// File: rtl/ilv_pulse_slot.sv
module ilv_pulse_slot #(
  parameter int CNT_W     = 12,
  parameter int BLANK_CYC = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] dutyReq,
  input  logic             stageEn,
  input  logic             curLimit,
  input  logic             forceOff,
  output logic             gate
);

  localparam logic [CNT_W-1:0] BLANK_Q = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] onCnt;
  logic [CNT_W-1:0] dutyQ;
  logic             endNow;

  // onCnt is the number of clocks the gate has been high, counting the current one.
  always_comb begin
    endNow = forceOff || !stageEn || (onCnt == dutyQ) ||
             (curLimit && (onCnt > BLANK_Q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate  <= 1'b0;
      onCnt <= '0;
      dutyQ <= '0;
    end else if (!gate) begin
      if (fire && stageEn && (dutyReq != '0)) begin
        gate  <= 1'b1;
        onCnt <= CNT_W'(1);
        dutyQ <= dutyReq;
      end
    end else if (endNow) begin
      gate <= 1'b0;
    end else begin
      onCnt <= onCnt + CNT_W'(1);
    end
  end

  // R2: a pulse never runs longer than its latched request
  a_r2_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (onCnt != '0 && onCnt <= dutyQ));

  // R7: a dropped enable ends the pulse on the next clock
  a_r7_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !stageEn) |=> !gate);

  // R5: an unblanked current limit ends the pulse on the next clock
  a_r5_limit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && curLimit && onCnt > BLANK_Q) |=> !gate);

  // R6: inside the blanking window nothing but enable, boundary or width ends the pulse
  a_r6_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && stageEn && !forceOff && onCnt <= BLANK_Q && onCnt < dutyQ) |=> gate);

endmodule

// File: rtl/ilv_pulse_path.sv
module ilv_pulse_path
  import ilv_gate_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int OFF_TIME  = 20,
  parameter int BLANK_CYC = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ilv_strobe_t      strb,
  input  logic [CNT_W-1:0] boostCap,
  input  logic [CNT_W-1:0] fwdCap,
  input  logic             boostEn,
  input  logic [CNT_W-1:0] boostDuty,
  input  logic             boostIlim,
  input  logic             fwdEn,
  input  logic [CNT_W-1:0] fwdDuty,
  input  logic             fwdIlim,
  output logic             boostGate,
  output logic             fwdGate
);

  localparam int RUN_W = (OFF_TIME < 2) ? 1 : $clog2(OFF_TIME);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(OFF_TIME - 1);

  logic [NUM_CH-1:0] fireV;
  logic [NUM_CH-1:0] enV;
  logic [NUM_CH-1:0] limV;
  logic [NUM_CH-1:0] offV;
  logic [NUM_CH-1:0] gateV;
  logic [CNT_W-1:0]  reqV [NUM_CH];

  logic             fwdArmed;
  logic [RUN_W-1:0] lowRun;
  logic             fwdFire;

  // Off-time tracker: counts clocks of low boost gate after the period start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwdArmed <= 1'b0;
      lowRun   <= '0;
    end else if (strb.periodStart) begin
      fwdArmed <= 1'b1;
      lowRun   <= '0;
    end else if (fwdArmed && !gateV[CH_BOOST]) begin
      if (lowRun == RUN_LAST) fwdArmed <= 1'b0;
      else                    lowRun   <= lowRun + RUN_W'(1);
    end
  end

  assign fwdFire = fwdArmed && !strb.periodStart && !strb.periodEnd &&
                   !gateV[CH_BOOST] && (lowRun == RUN_LAST);

  // Per-stage request clamping and control routing.
  always_comb begin
    reqV[CH_BOOST]  = (boostDuty > boostCap) ? boostCap : boostDuty;
    reqV[CH_FWD]    = (fwdDuty > fwdCap) ? fwdCap : fwdDuty;
    fireV[CH_BOOST] = strb.periodStart;
    fireV[CH_FWD]   = fwdFire;
    enV[CH_BOOST]   = boostEn;
    enV[CH_FWD]     = fwdEn;
    limV[CH_BOOST]  = boostIlim;
    limV[CH_FWD]    = fwdIlim;
    offV[CH_BOOST]  = strb.periodEnd;
    offV[CH_FWD]    = strb.periodEnd;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    ilv_pulse_slot #(
      .CNT_W    (CNT_W),
      .BLANK_CYC(BLANK_CYC)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fireV[ch]),
      .dutyReq (reqV[ch]),
      .stageEn (enV[ch]),
      .curLimit(limV[ch]),
      .forceOff(offV[ch]),
      .gate    (gateV[ch])
    );
  end

  assign boostGate = gateV[CH_BOOST];
  assign fwdGate   = gateV[CH_FWD];

  // R3: the two stages never conduct together
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(boostGate && fwdGate));

  // R3: a forward turn-on is preceded by low boost gate
  a_r3_offtime_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwdGate) |-> (!boostGate && !$past(boostGate)));

  // R9: both gates stay low while reset is held
  a_r9_reset_low: assert property (@(posedge clk)
    !rst_n |-> (!boostGate && !fwdGate));

endmodule

// File: rtl/ilv_gate_pulser.sv
module ilv_gate_pulser
  import ilv_gate_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int MIN_PERIOD   = 64,
  parameter int MAX_PERIOD   = 3076,
  parameter int OFF_TIME     = 20,
  parameter int BLANK_CYC    = 35,
  parameter int STRETCH_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             lightLoad,
  input  logic             dutySel,
  input  logic             boostEn,
  input  logic [CNT_W-1:0] boostDuty,
  input  logic             boostIlim,
  input  logic             fwdEn,
  input  logic [CNT_W-1:0] fwdDuty,
  input  logic             fwdIlim,
  output logic             boostGate,
  output logic             fwdGate
);

  ilv_strobe_t      strb;
  logic [CNT_W-1:0] boostCap;
  logic [CNT_W-1:0] fwdCap;

  ilv_period_ctrl #(
    .CNT_W       (CNT_W),
    .MIN_PERIOD  (MIN_PERIOD),
    .MAX_PERIOD  (MAX_PERIOD),
    .STRETCH_STEP(STRETCH_STEP)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .periodCfg(periodCfg),
    .lightLoad(lightLoad),
    .dutySel  (dutySel),
    .strb     (strb),
    .boostCap (boostCap),
    .fwdCap   (fwdCap)
  );

  ilv_pulse_path #(
    .CNT_W    (CNT_W),
    .OFF_TIME (OFF_TIME),
    .BLANK_CYC(BLANK_CYC)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .boostCap (boostCap),
    .fwdCap   (fwdCap),
    .boostEn  (boostEn),
    .boostDuty(boostDuty),
    .boostIlim(boostIlim),
    .fwdEn    (fwdEn),
    .fwdDuty  (fwdDuty),
    .fwdIlim  (fwdIlim),
    .boostGate(boostGate),
    .fwdGate  (fwdGate)
  );

endmodule

// File: tb/ilv_gate_pulser_bench.sv
module ilv_gate_pulser_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W   = 10;
  localparam int MIN_P   = 64;
  localparam int MAX_P   = 256;
  localparam int OFF     = 4;
  localparam int BLANK   = 6;
  localparam int STEP    = 16;
  localparam int WD_CYC  = 190000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] periodCfg = CNT_W'(128);
  logic             lightLoad = 1'b0;
  logic             dutySel = 1'b0;
  logic             boostEn = 1'b1;
  logic [CNT_W-1:0] boostDuty = CNT_W'(20);
  logic             boostIlim = 1'b0;
  logic             fwdEn = 1'b1;
  logic [CNT_W-1:0] fwdDuty = CNT_W'(20);
  logic             fwdIlim = 1'b0;
  logic             boostGate;
  logic             fwdGate;

  int nChecks = 0;
  int nFail = 0;

  ilv_gate_pulser #(
    .CNT_W(CNT_W), .MIN_PERIOD(MIN_P), .MAX_PERIOD(MAX_P),
    .OFF_TIME(OFF), .BLANK_CYC(BLANK), .STRETCH_STEP(STEP)
  ) u_ilv_gate_pulser (
    .clk(clk), .rst_n(rst_n), .periodCfg(periodCfg), .lightLoad(lightLoad),
    .dutySel(dutySel), .boostEn(boostEn), .boostDuty(boostDuty),
    .boostIlim(boostIlim), .fwdEn(fwdEn), .fwdDuty(fwdDuty), .fwdIlim(fwdIlim),
    .boostGate(boostGate), .fwdGate(fwdGate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Edge monitor: tick stamps of every gate edge, sampled at the falling clock edge.
  int   tick = 0;
  int   bRise = -100000, bFall = -100000, fRise = -100000, fFall = -100000;
  int   bHigh = 0;
  logic bPrev = 1'b0, fPrev = 1'b0;

  always @(negedge clk) begin
    tick = tick + 1;
    if (boostGate && !bPrev) bRise = tick;
    if (!boostGate && bPrev) bFall = tick;
    if (fwdGate && !fPrev)   fRise = tick;
    if (!fwdGate && fPrev)   fFall = tick;
    if (boostGate) bHigh = bHigh + 1;
    bPrev = boostGate;
    fPrev = fwdGate;
  end

  task automatic expect_eq(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step_clk();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_boost_rise(output int t);
    int prev;
    prev = bRise;
    do step_clk(); while (bRise == prev);
    t = bRise;
  endtask

  task automatic wait_fwd_rise(output int t);
    int prev;
    prev = fRise;
    do step_clk(); while (fRise == prev);
    t = fRise;
  endtask

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int clampP(int p);
    return (p < MIN_P) ? MIN_P : ((p > MAX_P) ? MAX_P : p);
  endfunction

  function automatic int fwdCapOf(int p, int s);
    return s ? (p/2 + p/8 + p/32) : p/2;
  endfunction

  task automatic set_cfg(int p, int b, int f, int s);
    periodCfg = CNT_W'(p);
    boostDuty = CNT_W'(b);
    fwdDuty   = CNT_W'(f);
    dutySel   = s[0];
  endtask

  // One sweep point: R1 period, R2 boost width, R3 gap, R4 forward width.
  task automatic sweep_point(int p, int b, int f, int s);
    int t0, t1, ep, bw, fstart, fw;
    set_cfg(p, b, f, s);
    wait_boost_rise(t0);
    wait_boost_rise(t1);
    ep = clampP(p);
    bw = imin(b, ep - ep/32);
    fstart = bw + OFF + 1;
    fw = (fstart < ep) ? imin(imin(f, fwdCapOf(ep, s)), ep - fstart) : 0;
    expect_eq("R1", "period", t1 - t0, ep);
    expect_eq("R2", "boost width", bFall - t0, bw);
    if (fw > 0) begin
      expect_eq("R3", "boost-to-forward gap", fRise - bFall, OFF);
      expect_eq("R4", "forward width", fFall - fRise, fw);
    end else begin
      expect_eq("R4", "forward pulse present", (fRise > t0 && fRise < t1) ? 1 : 0, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYC);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int t0, t1, t2, pPrev, pNow, hc0;
    int plist [5] = '{64, 97, 128, 200, 256};

    // R9: gates held low in reset
    for (int i = 0; i < 4; i++) begin
      step_clk();
      expect_eq("R9", "boost gate in reset", int'(boostGate), 0);
      expect_eq("R9", "forward gate in reset", int'(fwdGate), 0);
    end
    rst_n = 1'b1;
    wait_boost_rise(t0);

    // R1..R4 sweep over period, boost duty, forward cap select and forward duty
    foreach (plist[k]) begin
      for (int b = 1; b <= plist[k] + 8; b += plist[k] / 5) begin
        for (int s = 0; s < 2; s++) begin
          sweep_point(plist[k], b, (b * 3) % plist[k] + 1, s);
          sweep_point(plist[k], b, 1000, s);
        end
      end
    end

    // R1: period requests outside the legal range are clamped
    sweep_point(20, 10, 10, 0);
    sweep_point(400, 10, 10, 0);

    // R5/R6: boost current limit held high
    set_cfg(128, 50, 30, 0);
    boostIlim = 1'b1;
    wait_boost_rise(t0); wait_boost_rise(t1);
    expect_eq("R5", "boost width under limit", bFall - t0, BLANK + 1);
    expect_eq("R3", "gap after limited boost", fRise - bFall, OFF);
    set_cfg(128, BLANK, 30, 0);
    wait_boost_rise(t0); wait_boost_rise(t1);
    expect_eq("R6", "boost width inside blanking", bFall - t0, BLANK);
    boostIlim = 1'b0;

    // R5/R6: forward current limit held high
    set_cfg(128, 20, 50, 0);
    fwdIlim = 1'b1;
    wait_boost_rise(t0); wait_boost_rise(t1);
    expect_eq("R5", "forward width under limit", fFall - fRise, BLANK + 1);
    set_cfg(128, 20, BLANK - 1, 0);
    wait_boost_rise(t0); wait_boost_rise(t1);
    expect_eq("R6", "forward width inside blanking", fFall - fRise, BLANK - 1);
    fwdIlim = 1'b0;

    // R7: boost enable dropped mid-pulse, restored at once
    set_cfg(128, 60, 20, 0);
    wait_boost_rise(t0); wait_boost_rise(t0);
    for (int i = 0; i < 9; i++) step_clk();
    boostEn = 1'b0;
    step_clk();
    expect_eq("R7", "boost gate after disable", int'(boostGate), 0);
    boostEn = 1'b1;
    wait_boost_rise(t1);
    expect_eq("R7", "boost width cut by disable", bFall - t0, 10);
    expect_eq("R7", "no boost restart before boundary", t1 - t0, 128);

    // R7: forward enable dropped mid-pulse, restored at once
    wait_fwd_rise(t0);
    for (int i = 0; i < 3; i++) step_clk();
    fwdEn = 1'b0;
    step_clk();
    expect_eq("R7", "forward gate after disable", int'(fwdGate), 0);
    fwdEn = 1'b1;
    wait_fwd_rise(t1);
    expect_eq("R7", "forward width cut by disable", fFall - t0, 4);
    expect_eq("R7", "no forward restart before boundary", t1 - t0, 128);

    // R2: zero boost request; forward still runs every period
    set_cfg(128, 0, 30, 0);
    wait_fwd_rise(t0); wait_fwd_rise(t1);
    hc0 = bHigh;
    wait_fwd_rise(t2);
    expect_eq("R2", "boost high clocks with zero request", bHigh - hc0, 0);
    expect_eq("R1", "forward spacing with no boost", t2 - t1, 128);
    expect_eq("R4", "forward width with no boost", fFall - t1, 30);

    // R2: boost disabled for whole periods
    set_cfg(128, 40, 30, 0);
    boostEn = 1'b0;
    wait_fwd_rise(t0); wait_fwd_rise(t1);
    hc0 = bHigh;
    wait_fwd_rise(t2);
    expect_eq("R2", "boost high clocks while disabled", bHigh - hc0, 0);
    boostEn = 1'b1;

    // R8: light-load stretch up to the ceiling, then return to nominal
    set_cfg(128, 20, 20, 0);
    wait_boost_rise(t0); wait_boost_rise(t0);
    lightLoad = 1'b1;
    pPrev = 128;
    wait_boost_rise(t0);
    for (int i = 0; i < 9; i++) begin
      wait_boost_rise(t1);
      pNow = t1 - t0;
      expect_eq("R8", "stretched period", pNow, imin(pPrev + STEP, MAX_P));
      pPrev = pNow;
      t0 = t1;
    end
    expect_eq("R8", "period at ceiling", pPrev, MAX_P);
    lightLoad = 1'b0;
    wait_boost_rise(t1);
    wait_boost_rise(t2);
    expect_eq("R8", "period after light load ends", t2 - t1, 128);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule